// File: doc/BRIEF.md
# Rotated-Parity Stripe Write Engine

This block handles single-block writes to a five-disk array. Each stripe holds four data blocks and one parity block. The parity block is the bitwise XOR of the four data blocks in its stripe. The disk that holds parity moves by one position from stripe to stripe, so small writes to different stripes do not all queue behind one parity disk.

A command brings in a logical block address and a new data block. The engine then runs a read-modify-write sequence on exactly two disks:

1. It reads the old data block and the old parity block.
2. It forms the new parity as old parity XOR old data XOR new data.
3. It writes the new data block and the new parity block.

Each disk has its own port. A request channel uses valid/ready and carries a write flag, the stripe number and write data; the disk is identified by its port index. A response strobe carries read data, and for a write it serves as the acknowledgement. A one-cycle completion pulse tells the issuer that the write has landed.

Top module: `stripe_rmw_engine`

## Requirements
- R1: `cmd_ready` is high only when the engine is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. While idle, no disk request is valid. While busy, the command inputs are ignored.
- R2: For stripe s = lba / 4, parity lives on disk 4 - (s mod 5). Disk 4 holds parity for stripe 0 and disk 0 for stripe 4, and the pattern repeats from stripe 5.
- R3: Data index i = lba mod 4 (the two low address bits) selects a data disk. The data blocks fill the four non-parity disks in ascending disk order, so the data disk is i when i is below the parity disk, and i + 1 otherwise.
- R4: The two reads (`dsk_req_wr` = 0) go to the data disk and the parity disk first. No write request (`dsk_req_wr` = 1) is raised until both read responses have returned.
- R5: The data disk is written with the new data. The parity disk is written with old parity XOR old data XOR new data, which keeps the XOR of the stripe's five blocks at zero.
- R6: One command causes exactly four accepted requests (two reads, two writes), all to the data disk and the parity disk. No more than two request valids are ever high at once.
- R7: `done` is high for exactly one cycle: the cycle after the last write acknowledgement is sampled. In the following cycle the engine is idle again.
- R8: A request whose valid is high while its ready is low stays valid, with unchanged write flag and data, until it is accepted.
- R9: Every request carries the stripe number lba / 4 in its stripe field.
- R10: A response strobe on a disk that has no request outstanding is ignored and does not affect the written parity.
- R11: After reset the engine is idle: `cmd_ready` is 1, and `done` and every request valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_lba | input | LBA_W | Logical block address of the write |
| cmd_data | input | BLK_W | New data block |
| done | output | 1 | One-cycle completion pulse |
| dsk_req_valid | output | 5 | Per-disk request valid |
| dsk_req_ready | input | 5 | Per-disk request ready |
| dsk_req_wr | output | 5 | Per-disk request is a write (1) or a read (0) |
| dsk_req_stripe | output | 5*(LBA_W-2) | Per-disk stripe number, disk g in slice g |
| dsk_req_data | output | 5*BLK_W | Per-disk write data, disk g in slice g |
| dsk_rsp_valid | input | 5 | Per-disk response strobe (read data or write acknowledgement) |
| dsk_rsp_data | input | 5*BLK_W | Per-disk read data, disk g in slice g |

## Verification
The bound checker covers the rules that hold on every cycle:
- no request while idle;
- at most two request valids at a time;
- a stalled request holds its valid until accepted;
- no write until two read responses on outstanding disks have been counted;
- a lone `done` pulse that follows four counted responses and is followed by idle.

The rest can only be shown by the bench's scenarios:
- which disks are picked as parity and data as the stripe number walks through the rotation and wraps;
- the parity value written back and the resulting zero stripe XOR;
- the stripe field;
- the exact `done` cycle;
- that stray responses and command inputs changing while busy leave the result untouched.

// File: rtl/stripe_rmw_engine.sv
module stripe_rmw_engine #(
  parameter int BLK_W = 32,
  parameter int LBA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [LBA_W-1:0]           cmd_lba,
  input  logic [BLK_W-1:0]           cmd_data,
  output logic                       done,
  output logic [4:0]                 dsk_req_valid,
  input  logic [4:0]                 dsk_req_ready,
  output logic [4:0]                 dsk_req_wr,
  output logic [5*(LBA_W-2)-1:0]     dsk_req_stripe,
  output logic [5*BLK_W-1:0]         dsk_req_data,
  input  logic [4:0]                 dsk_rsp_valid,
  input  logic [5*BLK_W-1:0]         dsk_rsp_data
);
  localparam int NDISK = 5;
  localparam int STR_W = LBA_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} st_t;
  st_t st;

  logic [2:0]       dd_q, pd_q;
  logic [STR_W-1:0] str_q;
  logic [BLK_W-1:0] new_q, old_d_q, old_p_q;
  logic             d_sent, p_sent, d_got, p_got;

  wire [STR_W-1:0] c_str = cmd_lba[LBA_W-1:2];
  wire [STR_W-1:0] c_mod = c_str % STR_W'(NDISK);
  wire [2:0]       c_pd  = 3'd4 - c_mod[2:0];
  wire [2:0]       c_idx = {1'b0, cmd_lba[1:0]};
  wire [2:0]       c_dd  = (c_idx < c_pd) ? c_idx : c_idx + 3'd1;

  wire busy  = (st != S_IDLE);
  wire d_acc = busy && !d_sent && dsk_req_ready[dd_q];
  wire p_acc = busy && !p_sent && dsk_req_ready[pd_q];
  wire d_rsp = d_sent && !d_got && dsk_rsp_valid[dd_q];
  wire p_rsp = p_sent && !p_got && dsk_rsp_valid[pd_q];
  wire both  = d_got && p_got;
  wire [BLK_W-1:0] par = old_p_q ^ old_d_q ^ new_q;

  assign cmd_ready = (st == S_IDLE);
  assign done      = (st == S_WRITE) && both;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dd_q    <= '0;
      pd_q    <= '0;
      str_q   <= '0;
      new_q   <= '0;
      old_d_q <= '0;
      old_p_q <= '0;
      d_sent  <= 1'b0;
      p_sent  <= 1'b0;
      d_got   <= 1'b0;
      p_got   <= 1'b0;
    end else if (st == S_IDLE) begin
      if (cmd_valid) begin
        st     <= S_READ;
        dd_q   <= c_dd;
        pd_q   <= c_pd;
        str_q  <= c_str;
        new_q  <= cmd_data;
        d_sent <= 1'b0;
        p_sent <= 1'b0;
        d_got  <= 1'b0;
        p_got  <= 1'b0;
      end
    end else begin
      if (d_acc) d_sent <= 1'b1;
      if (p_acc) p_sent <= 1'b1;
      if (d_rsp) begin
        d_got <= 1'b1;
        if (st == S_READ) old_d_q <= dsk_rsp_data[int'(dd_q)*BLK_W +: BLK_W];
      end
      if (p_rsp) begin
        p_got <= 1'b1;
        if (st == S_READ) old_p_q <= dsk_rsp_data[int'(pd_q)*BLK_W +: BLK_W];
      end
      if (both) begin
        d_sent <= 1'b0;
        p_sent <= 1'b0;
        d_got  <= 1'b0;
        p_got  <= 1'b0;
        st     <= (st == S_READ) ? S_WRITE : S_IDLE;
      end
    end
  end

  for (genvar g = 0; g < NDISK; g++) begin : g_port
    wire is_d = (dd_q == 3'(g));
    wire is_p = (pd_q == 3'(g));
    assign dsk_req_valid[g] = busy && ((is_d && !d_sent) || (is_p && !p_sent));
    assign dsk_req_wr[g]    = (st == S_WRITE);
    assign dsk_req_stripe[g*STR_W +: STR_W] = str_q;
    assign dsk_req_data[g*BLK_W +: BLK_W] =
      (st != S_WRITE) ? '0 : (is_p ? par : new_q);
  end
endmodule

// File: rtl/stripe_rmw_engine_chk.sv
module stripe_rmw_engine_chk #(
  parameter int BLK_W = 32,
  parameter int LBA_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   done,
  input logic [4:0]             dsk_req_valid,
  input logic [4:0]             dsk_req_ready,
  input logic [4:0]             dsk_req_wr,
  input logic [5*BLK_W-1:0]     dsk_req_data,
  input logic [4:0]             dsk_rsp_valid
);
  logic [4:0] outst;
  logic [3:0] rsp_cnt;
  wire  [4:0] stalled = dsk_req_valid & ~dsk_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst   <= '0;
      rsp_cnt <= '0;
    end else begin
      outst <= (outst & ~dsk_rsp_valid) | (dsk_req_valid & dsk_req_ready);
      if (cmd_valid && cmd_ready) rsp_cnt <= '0;
      else if (rsp_cnt < 4'd8) rsp_cnt <= rsp_cnt + 4'($countones(dsk_rsp_valid & outst));
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (dsk_req_valid == 5'd0));

  p_two_disks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dsk_req_valid) <= 2);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|stalled) |=> (($past(stalled) & dsk_req_valid) == $past(stalled)));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|stalled) |=> $stable(dsk_req_data));

  p_reads_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dsk_req_valid & dsk_req_wr)) |-> (rsp_cnt >= 4'd2));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  p_done_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_cnt == 4'd4));
endmodule

bind stripe_rmw_engine stripe_rmw_engine_chk #(.BLK_W(BLK_W), .LBA_W(LBA_W)) u_chk (.*);

// File: tb/stripe_rmw_engine_tb_top.sv
`timescale 1ns/1ps
module stripe_rmw_engine_tb_top;
  localparam int BLK_W = 32;
  localparam int LBA_W = 16;
  localparam int STR_W = LBA_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [LBA_W-1:0] cmd_lba = '0;
  logic [BLK_W-1:0] cmd_data = '0;
  logic done;
  logic [4:0] dsk_req_valid, dsk_req_wr;
  logic [4:0] dsk_req_ready = '0;
  logic [5*STR_W-1:0] dsk_req_stripe;
  logic [5*BLK_W-1:0] dsk_req_data;
  logic [4:0] dsk_rsp_valid = '0;
  logic [5*BLK_W-1:0] dsk_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [0:4][0:7];

  always #2.5 clk = ~clk;

  stripe_rmw_engine #(.BLK_W(BLK_W), .LBA_W(LBA_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic test_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "cmd_ready after reset", cmd_ready, 1);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(dsk_req_valid == 5'd0, "R11", "request valids after reset", dsk_req_valid, 0);
  endtask

  task automatic run_write(input int lba, input logic [31:0] val, input int stall,
                           input int dly, input bit junk, input bit hold, input string tag);
    int s, idx, pd, dd, cyc, nacc, nwr, rd_rsp, last_ack, done_at, bad_disk, bad_str, order_err;
    int hold_err, busy_rdy, quiet_err;
    bit srp, srd, swp, swd, wr_data_ok, par_ok, rdy;
    int pend [5];
    bit pwr [5];
    logic [4:0] waitm;
    logic [31:0] pdat [5];
    logic [4:0] pwrf;
    logic [31:0] exp_par, x;

    s = lba / 4; idx = lba % 4;
    pd = 4 - (s % 5);
    dd = (idx < pd) ? idx : idx + 1;
    exp_par = mem[pd][s] ^ mem[dd][s] ^ val;
    {cyc, nacc, nwr, rd_rsp, bad_disk, bad_str, order_err, hold_err, busy_rdy, quiet_err} = '0;
    last_ack = -1; done_at = -1;
    {srp, srd, swp, swd} = '0;
    wr_data_ok = 1'b1; par_ok = 1'b1;
    waitm = '0; pwrf = '0;
    for (int g = 0; g < 5; g++) begin pend[g] = -1; pwr[g] = 1'b0; pdat[g] = '0; end

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", {tag, " ready before command"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_lba = LBA_W'(lba); cmd_data = val;

    while (done_at < 0 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        if (hold) begin cmd_lba = LBA_W'(lba ^ 1); cmd_data = ~val; end
        else cmd_valid = 1'b0;
      end
      dsk_rsp_valid = '0;
      if (done) begin
        done_at = cyc;
        if (hold) cmd_valid = 1'b0;
      end else if (cmd_ready) busy_rdy++;
      for (int g = 0; g < 5; g++)
        if (waitm[g] && (!dsk_req_valid[g] || dsk_req_wr[g] != pwrf[g] ||
                         dsk_req_data[g*BLK_W +: BLK_W] != pdat[g])) hold_err++;
      for (int g = 0; g < 5; g++) begin
        if (pend[g] > 0) pend[g]--;
        if (pend[g] == 0) begin
          dsk_rsp_valid[g] = 1'b1;
          dsk_rsp_data[g*BLK_W +: BLK_W] = pwr[g] ? 32'hDEAD_0000 : mem[g][s];
          if (pwr[g]) last_ack = cyc; else rd_rsp++;
          pend[g] = -1;
        end else if (junk && g != dd && g != pd) begin
          dsk_rsp_valid[g] = 1'b1;
          dsk_rsp_data[g*BLK_W +: BLK_W] = $urandom;
        end
      end
      if (done_at >= 0) break;
      rdy = (stall == 0) || (cyc % (stall + 1) == 0);
      dsk_req_ready = rdy ? 5'h1f : 5'h00;
      for (int g = 0; g < 5; g++) begin
        if (dsk_req_valid[g] && rdy) begin
          nacc++;
          if (g != dd && g != pd) bad_disk++;
          if (dsk_req_stripe[g*STR_W +: STR_W] != STR_W'(s)) bad_str++;
          if (dsk_req_wr[g]) begin
            nwr++;
            if (rd_rsp < 2) order_err++;
            if (g == dd) begin swd = 1'b1; if (dsk_req_data[g*BLK_W +: BLK_W] != val) wr_data_ok = 1'b0; end
            if (g == pd) begin swp = 1'b1; if (dsk_req_data[g*BLK_W +: BLK_W] != exp_par) par_ok = 1'b0; end
            mem[g][s] = dsk_req_data[g*BLK_W +: BLK_W];
          end else begin
            if (nwr > 0) order_err++;
            if (g == dd) srd = 1'b1;
            if (g == pd) srp = 1'b1;
          end
          pend[g] = dly; pwr[g] = dsk_req_wr[g];
        end
      end
      waitm = rdy ? 5'h00 : dsk_req_valid;
      pwrf = dsk_req_wr;
      for (int g = 0; g < 5; g++) pdat[g] = dsk_req_data[g*BLK_W +: BLK_W];
    end
    dsk_rsp_valid = '0;
    dsk_req_ready = '0;

    chk(done_at >= 0, "R7", {tag, " done seen before timeout"}, done_at, 1);
    chk(done_at == last_ack + 1, "R7", {tag, " done one cycle after last ack"}, done_at, last_ack + 1);
    chk(busy_rdy == 0, "R1", {tag, " cmd_ready low while busy"}, busy_rdy, 0);
    chk(srp && swp, "R2", {tag, " parity disk read and written"}, {srp, swp}, 2'b11);
    chk(srd && swd, "R3", {tag, " data disk read and written"}, {srd, swd}, 2'b11);
    chk(order_err == 0 && nwr == 2, "R4", {tag, " reads before writes"}, order_err, 0);
    chk(wr_data_ok, "R5", {tag, " new data written"}, mem[dd][s], val);
    chk(par_ok, "R5", {tag, " new parity written"}, mem[pd][s], exp_par);
    x = '0;
    for (int g = 0; g < 5; g++) x ^= mem[g][s];
    chk(x == 32'h0, "R5", {tag, " stripe XOR zero"}, x, 0);
    chk(nacc == 4 && bad_disk == 0, "R6", {tag, " four requests on two disks"}, nacc, 4);
    chk(bad_str == 0, "R9", {tag, " stripe field"}, bad_str, 0);
    if (stall > 0) chk(hold_err == 0, "R8", {tag, " stalled request held"}, hold_err, 0);
    if (junk) chk(par_ok, "R10", {tag, " stray responses ignored"}, mem[pd][s], exp_par);
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R7", {tag, " single pulse then idle"}, {done, cmd_ready}, 2'b01);
    if (dsk_req_valid != 5'd0) quiet_err++;
    chk(quiet_err == 0, "R1", {tag, " no request after completion"}, dsk_req_valid, 0);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) begin
      logic [31:0] p;
      p = '0;
      for (int g = 0; g < 5; g++)
        if (g != 4 - (s % 5)) begin
          mem[g][s] = 32'h1357_9BDF * (s * 5 + g + 1) ^ 32'hA5A5_0F0F;
          p ^= mem[g][s];
        end
      mem[4 - (s % 5)][s] = p;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_write(0,  32'h1111_2222, 0, 1, 1'b0, 1'b0, "lba0");
    run_write(5,  32'hCAFE_F00D, 2, 2, 1'b0, 1'b0, "lba5_stall");
    run_write(11, 32'h0BAD_BEEF, 0, 3, 1'b1, 1'b0, "lba11_junk");
    run_write(14, 32'h8000_0001, 1, 1, 1'b0, 1'b1, "lba14_hold");
    run_write(16, 32'hFFFF_FFFF, 3, 1, 1'b1, 1'b0, "lba16_pd0");
    run_write(20, 32'h0000_0000, 0, 2, 1'b0, 1'b0, "lba20_wrap");
    run_write(21, 32'h5A5A_5A5A, 0, 1, 1'b0, 1'b0, "lba21_same_stripe");
    finish_run();
  end
endmodule